// File: doc/BRIEF.md
# Asymmetric Dual-Issue Pairing Stage

This block is the in-order issue stage of a two-pipe integer core. The two oldest entries of an external decoded-instruction queue come in as slot 0 (older) and slot 1 (younger). Each entry carries a valid bit, a 3-bit operation class, two source register indices and a destination register index. Each cycle the block looks at both entries together and decides whether they can leave as a pair. It returns a dequeue count so the queue can pop the entries that were taken.

Pipe A, the primary pipe, accepts any class. Pipe B is restricted. The younger instruction joins the older one only when pipe B can execute its class, when the older one is not a branch, and when it has no register dependence on the older one. If any of these fails, the older instruction goes alone on pipe A and pipe B gets a bubble. Every issued instruction gets a sequence number. A short tracker then carries each pair through the execute and write-back stages and presents the retirements in program order, with the pipe A instruction in the first retire slot and the pipe B instruction in the second.

Top module: `dual_issue_pair`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both issue outputs and both retire outputs are invalid, and the first instruction issued after reset carries sequence number 0.
- R2: When slot 0 is invalid, `deq_cnt` is 0 whatever slot 1 holds, and in the next cycle both pipes show a bubble.
- R3: When only slot 0 is valid, or the pair is refused, `deq_cnt` is 1. In the next cycle pipe A carries slot 0's class and registers and pipe B is invalid.
- R4: When the pair is accepted, `deq_cnt` is 2. In the next cycle pipe A carries slot 0 and pipe B carries slot 1, with all fields unchanged. Pipe B is never valid without pipe A.
- R5: Pipe B accepts class codes 0 (ALU), 1 (shift), 2 (load), 4 (branch) and 7 (move). A younger instruction of class 3 (store), 5 (multiply/divide) or 6 (system) is never paired.
- R6: An older instruction of class 4 (branch) is never paired. A younger branch may be paired.
- R7: The pair is refused when the younger instruction's rs1 or rs2 equals the older instruction's rd and that rd is not zero. Register 0 never creates a hazard.
- R8: The pair is refused when both instructions have the same non-zero rd.
- R9: While `stall` is high, `deq_cnt` is 0, both pipes show a bubble in the next cycle, and no sequence number is used up.
- R10: Sequence numbers count up by one per issued instruction, modulo 2^SEQ_W. Pipe A gets the next number and pipe B gets the number after it.
- R11: Every issued instruction appears on the retire outputs exactly two cycles after it appears on its issue outputs, with its rd and sequence number. The pipe A instruction uses retire slot A and the pipe B instruction uses slot B. Slot B is valid only when slot A is valid, and slot B's number is one higher than slot A's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Downstream hold; blocks issue and dequeue |
| q0_valid | input | 1 | Older queue entry present |
| q0_cls | input | 3 | Older entry class code |
| q0_rs1 | input | REG_W | Older entry first source |
| q0_rs2 | input | REG_W | Older entry second source |
| q0_rd | input | REG_W | Older entry destination (0 = none) |
| q1_valid | input | 1 | Younger queue entry present |
| q1_cls | input | 3 | Younger entry class code |
| q1_rs1 | input | REG_W | Younger entry first source |
| q1_rs2 | input | REG_W | Younger entry second source |
| q1_rd | input | REG_W | Younger entry destination |
| deq_cnt | output | 2 | Entries the queue must pop this cycle |
| pa_valid | output | 1 | Pipe A issue valid |
| pa_cls | output | 3 | Pipe A class |
| pa_rs1 | output | REG_W | Pipe A first source |
| pa_rs2 | output | REG_W | Pipe A second source |
| pa_rd | output | REG_W | Pipe A destination |
| pa_seq | output | SEQ_W | Pipe A sequence number |
| pb_valid | output | 1 | Pipe B issue valid |
| pb_cls | output | 3 | Pipe B class |
| pb_rs1 | output | REG_W | Pipe B first source |
| pb_rs2 | output | REG_W | Pipe B second source |
| pb_rd | output | REG_W | Pipe B destination |
| pb_seq | output | SEQ_W | Pipe B sequence number |
| rt_a_valid | output | 1 | Retire slot A valid (retires first) |
| rt_a_rd | output | REG_W | Retire slot A destination |
| rt_a_seq | output | SEQ_W | Retire slot A sequence number |
| rt_b_valid | output | 1 | Retire slot B valid |
| rt_b_rd | output | REG_W | Retire slot B destination |
| rt_b_seq | output | SEQ_W | Retire slot B sequence number |

## Verification
The hardest cases to reach from the ports are pairs that pass every legality test except one. Random traffic rarely produces a younger instruction in a class pipe B accepts that also touches exactly the older rd, or a zero rd that looks like a hazard but must not block pairing. The stimulus therefore starts with a directed series in which each vector differs from an accepted pair in a single field. After that comes long random traffic drawn from only eight register indices, so that true and false dependences occur often. Occasional stalls are mixed into the random traffic so that the sequence count and the retire slots are checked across frozen cycles.

// File: rtl/dip_pkg.sv
package dip_pkg;
    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CL_ALU    = 3'd0,
        CL_SHIFT  = 3'd1,
        CL_LOAD   = 3'd2,
        CL_STORE  = 3'd3,
        CL_BRANCH = 3'd4,
        CL_MULDIV = 3'd5,
        CL_SYS    = 3'd6,
        CL_MOVE   = 3'd7
    } iclass_e;

    // Default mask of classes that the restricted pipe accepts
    localparam logic [2**CLS_W-1:0] SEC_MASK_DEF = 8'b1001_0111;

    function automatic logic sec_legal(input logic [CLS_W-1:0] cls,
                                       input logic [2**CLS_W-1:0] mask);
        return mask[cls];
    endfunction
endpackage

// File: rtl/dip_pair_check.sv
module dip_pair_check
    import dip_pkg::*;
#(
    parameter int                  REG_W    = 5,
    parameter logic [2**CLS_W-1:0] SEC_MASK = SEC_MASK_DEF
) (
    input  logic             old_v,
    input  logic [CLS_W-1:0] old_cls,
    input  logic [REG_W-1:0] old_rd,
    input  logic             yng_v,
    input  logic [CLS_W-1:0] yng_cls,
    input  logic [REG_W-1:0] yng_rs1,
    input  logic [REG_W-1:0] yng_rs2,
    input  logic [REG_W-1:0] yng_rd,
    output logic             pair_ok
);
    logic old_writes;
    logic raw_haz;
    logic waw_haz;
    logic class_ok;

    always_comb begin
        old_writes = (old_rd != '0);
        raw_haz    = old_writes && ((yng_rs1 == old_rd) || (yng_rs2 == old_rd));
        waw_haz    = old_writes && (yng_rd == old_rd);
        class_ok   = sec_legal(yng_cls, SEC_MASK) && (old_cls != CL_BRANCH);
        pair_ok    = old_v && yng_v && class_ok && !raw_haz && !waw_haz;
    end
endmodule

// File: rtl/dip_retire_track.sv
module dip_retire_track #(
    parameter int REG_W       = 5,
    parameter int SEQ_W       = 8,
    parameter int EXEC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_a_v,
    input  logic [REG_W-1:0] in_a_rd,
    input  logic [SEQ_W-1:0] in_a_seq,
    input  logic             in_b_v,
    input  logic [REG_W-1:0] in_b_rd,
    input  logic [SEQ_W-1:0] in_b_seq,
    output logic             rt_a_v,
    output logic [REG_W-1:0] rt_a_rd,
    output logic [SEQ_W-1:0] rt_a_seq,
    output logic             rt_b_v,
    output logic [REG_W-1:0] rt_b_rd,
    output logic [SEQ_W-1:0] rt_b_seq
);
    localparam int LAST = EXEC_STAGES - 1;

    typedef struct packed {
        logic             v;
        logic [REG_W-1:0] rd;
        logic [SEQ_W-1:0] seq;
    } ret_t;

    typedef struct packed {
        ret_t a;
        ret_t b;
    } pair_t;

    pair_t stg_d [EXEC_STAGES];
    pair_t stg_q [EXEC_STAGES];

    for (genvar g = 0; g < EXEC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_comb begin
                stg_d[g].a = '{v: in_a_v, rd: in_a_rd, seq: in_a_seq};
                // slot B only travels alongside a valid slot A
                stg_d[g].b = '{v: in_b_v && in_a_v, rd: in_b_rd, seq: in_b_seq};
            end
        end else begin : g_body
            always_comb stg_d[g] = stg_q[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= '0;
            else        stg_q[g] <= stg_d[g];
        end
    end

    always_comb begin
        rt_a_v   = stg_q[LAST].a.v;
        rt_a_rd  = stg_q[LAST].a.rd;
        rt_a_seq = stg_q[LAST].a.seq;
        rt_b_v   = stg_q[LAST].b.v;
        rt_b_rd  = stg_q[LAST].b.rd;
        rt_b_seq = stg_q[LAST].b.seq;
    end
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
    import dip_pkg::*;
#(
    parameter int                  REG_W       = 5,
    parameter int                  SEQ_W       = 8,
    parameter int                  EXEC_STAGES = 2,
    parameter logic [2**CLS_W-1:0] SEC_MASK    = SEC_MASK_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic             q0_valid,
    input  logic [CLS_W-1:0] q0_cls,
    input  logic [REG_W-1:0] q0_rs1,
    input  logic [REG_W-1:0] q0_rs2,
    input  logic [REG_W-1:0] q0_rd,
    input  logic             q1_valid,
    input  logic [CLS_W-1:0] q1_cls,
    input  logic [REG_W-1:0] q1_rs1,
    input  logic [REG_W-1:0] q1_rs2,
    input  logic [REG_W-1:0] q1_rd,
    output logic [1:0]       deq_cnt,
    output logic             pa_valid,
    output logic [CLS_W-1:0] pa_cls,
    output logic [REG_W-1:0] pa_rs1,
    output logic [REG_W-1:0] pa_rs2,
    output logic [REG_W-1:0] pa_rd,
    output logic [SEQ_W-1:0] pa_seq,
    output logic             pb_valid,
    output logic [CLS_W-1:0] pb_cls,
    output logic [REG_W-1:0] pb_rs1,
    output logic [REG_W-1:0] pb_rs2,
    output logic [REG_W-1:0] pb_rd,
    output logic [SEQ_W-1:0] pb_seq,
    output logic             rt_a_valid,
    output logic [REG_W-1:0] rt_a_rd,
    output logic [SEQ_W-1:0] rt_a_seq,
    output logic             rt_b_valid,
    output logic [REG_W-1:0] rt_b_rd,
    output logic [SEQ_W-1:0] rt_b_seq
);
    typedef struct packed {
        logic             v;
        logic [CLS_W-1:0] cls;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
        logic [REG_W-1:0] rd;
        logic [SEQ_W-1:0] seq;
    } slot_t;

    typedef struct packed {
        slot_t            a;
        slot_t            b;
        logic [SEQ_W-1:0] nxt;
    } iss_t;

    iss_t iss_d, iss_q;
    logic pair_ok;
    logic [1:0] deq_d;

    dip_pair_check #(
        .REG_W    (REG_W),
        .SEC_MASK (SEC_MASK)
    ) u_check (
        .old_v   (q0_valid),
        .old_cls (q0_cls),
        .old_rd  (q0_rd),
        .yng_v   (q1_valid),
        .yng_cls (q1_cls),
        .yng_rs1 (q1_rs1),
        .yng_rs2 (q1_rs2),
        .yng_rd  (q1_rd),
        .pair_ok (pair_ok)
    );

    always_comb begin
        iss_d = iss_q;
        deq_d = 2'd0;
        iss_d.a.v = 1'b0;
        iss_d.b.v = 1'b0;
        if (!stall && q0_valid) begin
            iss_d.a = '{v: 1'b1, cls: q0_cls, rs1: q0_rs1, rs2: q0_rs2,
                        rd: q0_rd, seq: iss_q.nxt};
            if (pair_ok) begin
                iss_d.b   = '{v: 1'b1, cls: q1_cls, rs1: q1_rs1, rs2: q1_rs2,
                              rd: q1_rd, seq: SEQ_W'(iss_q.nxt + 1'b1)};
                iss_d.nxt = SEQ_W'(iss_q.nxt + 2'd2);
                deq_d     = 2'd2;
            end else begin
                iss_d.nxt = SEQ_W'(iss_q.nxt + 1'b1);
                deq_d     = 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) iss_q <= '0;
        else        iss_q <= iss_d;
    end

    always_comb begin
        deq_cnt  = deq_d;
        pa_valid = iss_q.a.v;
        pa_cls   = iss_q.a.cls;
        pa_rs1   = iss_q.a.rs1;
        pa_rs2   = iss_q.a.rs2;
        pa_rd    = iss_q.a.rd;
        pa_seq   = iss_q.a.seq;
        pb_valid = iss_q.b.v;
        pb_cls   = iss_q.b.cls;
        pb_rs1   = iss_q.b.rs1;
        pb_rs2   = iss_q.b.rs2;
        pb_rd    = iss_q.b.rd;
        pb_seq   = iss_q.b.seq;
    end

    dip_retire_track #(
        .REG_W       (REG_W),
        .SEQ_W       (SEQ_W),
        .EXEC_STAGES (EXEC_STAGES)
    ) u_retire (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_a_v   (iss_q.a.v),
        .in_a_rd  (iss_q.a.rd),
        .in_a_seq (iss_q.a.seq),
        .in_b_v   (iss_q.b.v),
        .in_b_rd  (iss_q.b.rd),
        .in_b_seq (iss_q.b.seq),
        .rt_a_v   (rt_a_valid),
        .rt_a_rd  (rt_a_rd),
        .rt_a_seq (rt_a_seq),
        .rt_b_v   (rt_b_valid),
        .rt_b_rd  (rt_b_rd),
        .rt_b_seq (rt_b_seq)
    );
endmodule

// File: rtl/dual_issue_pair_chk.sv
module dual_issue_pair_chk
    import dip_pkg::*;
#(
    parameter int                  SEQ_W    = 8,
    parameter logic [2**CLS_W-1:0] SEC_MASK = SEC_MASK_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stall,
    input logic             q0_valid,
    input logic [1:0]       deq_cnt,
    input logic             pa_valid,
    input logic [SEQ_W-1:0] pa_seq,
    input logic             pb_valid,
    input logic [CLS_W-1:0] pb_cls,
    input logic [SEQ_W-1:0] pb_seq,
    input logic             rt_a_valid,
    input logic [SEQ_W-1:0] rt_a_seq,
    input logic             rt_b_valid,
    input logic [SEQ_W-1:0] rt_b_seq
);
    AST_B_NEEDS_A: assert property (@(posedge clk) disable iff (!rst_n) pb_valid |-> pa_valid); // R4
    AST_EMPTY_NO_DEQ: assert property (@(posedge clk) disable iff (!rst_n) !q0_valid |-> deq_cnt == 2'd0); // R2
    AST_STALL_NO_DEQ: assert property (@(posedge clk) disable iff (!rst_n) stall |-> deq_cnt == 2'd0); // R9
    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n) stall |=> (!pa_valid && !pb_valid)); // R9
    AST_DEQ_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) deq_cnt == 2'd1 |=> (pa_valid && !pb_valid)); // R3
    AST_DEQ_TWO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) deq_cnt == 2'd2 |=> (pa_valid && pb_valid)); // R4
    AST_SEC_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) pb_valid |-> SEC_MASK[pb_cls]); // R5
    AST_SEQ_PAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n) pb_valid |-> pb_seq == SEQ_W'(pa_seq + 1'b1)); // R10
    AST_RET_ORDER: assert property (@(posedge clk) disable iff (!rst_n) rt_b_valid |-> (rt_a_valid && rt_b_seq == SEQ_W'(rt_a_seq + 1'b1))); // R11
endmodule

bind dual_issue_pair dual_issue_pair_chk #(
    .SEQ_W    (SEQ_W),
    .SEC_MASK (SEC_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .q0_valid   (q0_valid),
    .deq_cnt    (deq_cnt),
    .pa_valid   (pa_valid),
    .pa_seq     (pa_seq),
    .pb_valid   (pb_valid),
    .pb_cls     (pb_cls),
    .pb_seq     (pb_seq),
    .rt_a_valid (rt_a_valid),
    .rt_a_seq   (rt_a_seq),
    .rt_b_valid (rt_b_valid),
    .rt_b_seq   (rt_b_seq)
);

// File: tb/tb_dual_issue_pair.sv
module tb_dual_issue_pair;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 5;
    localparam int SW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stall = 1'b0;
    logic q0_valid = 1'b0, q1_valid = 1'b0;
    logic [2:0] q0_cls = '0, q1_cls = '0;
    logic [RW-1:0] q0_rs1 = '0, q0_rs2 = '0, q0_rd = '0;
    logic [RW-1:0] q1_rs1 = '0, q1_rs2 = '0, q1_rd = '0;
    logic [1:0] deq_cnt;
    logic pa_valid, pb_valid, rt_a_valid, rt_b_valid;
    logic [2:0] pa_cls, pb_cls;
    logic [RW-1:0] pa_rs1, pa_rs2, pa_rd, pb_rs1, pb_rs2, pb_rd, rt_a_rd, rt_b_rd;
    logic [SW-1:0] pa_seq, pb_seq, rt_a_seq, rt_b_seq;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_issue_pair dut (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .q0_valid(q0_valid), .q0_cls(q0_cls), .q0_rs1(q0_rs1), .q0_rs2(q0_rs2), .q0_rd(q0_rd),
        .q1_valid(q1_valid), .q1_cls(q1_cls), .q1_rs1(q1_rs1), .q1_rs2(q1_rs2), .q1_rd(q1_rd),
        .deq_cnt(deq_cnt),
        .pa_valid(pa_valid), .pa_cls(pa_cls), .pa_rs1(pa_rs1), .pa_rs2(pa_rs2), .pa_rd(pa_rd), .pa_seq(pa_seq),
        .pb_valid(pb_valid), .pb_cls(pb_cls), .pb_rs1(pb_rs1), .pb_rs2(pb_rs2), .pb_rd(pb_rd), .pb_seq(pb_seq),
        .rt_a_valid(rt_a_valid), .rt_a_rd(rt_a_rd), .rt_a_seq(rt_a_seq),
        .rt_b_valid(rt_b_valid), .rt_b_rd(rt_b_rd), .rt_b_seq(rt_b_seq)
    );

    typedef struct packed {
        logic v; logic [2:0] c; logic [RW-1:0] r1, r2, d; logic [SW-1:0] s;
    } ref_t;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int seq_ctr = 0;
    int lcg = 32'h1234_5679;
    string tag = "R1";
    ref_t iss_a, iss_b, ex_a, ex_b, wb_a, wb_b;
    int exp_deq;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, got, exp);
        end
    endtask

    function automatic bit ref_legal_b(input logic [2:0] c);
        return (c == 3'd0) || (c == 3'd1) || (c == 3'd2) || (c == 3'd4) || (c == 3'd7);
    endfunction

    function automatic int ref_deq();
        bit dep, ok;
        if (stall || !q0_valid) return 0;
        dep = (q0_rd != 0) && (q1_rs1 == q0_rd || q1_rs2 == q0_rd || q1_rd == q0_rd);
        ok = q1_valid && ref_legal_b(q1_cls) && (q0_cls != 3'd4) && !dep;
        return ok ? 2 : 1;
    endfunction

    task automatic cmp_issue(input string which, input ref_t e, input logic v, input logic [2:0] c,
                             input logic [RW-1:0] r1, input logic [RW-1:0] r2,
                             input logic [RW-1:0] d, input logic [SW-1:0] s);
        if (e.v) begin
            check(v && c == e.c && r1 == e.r1 && r2 == e.r2 && d == e.d, tag, which,
                  {v, c, r1, r2, d}, {e.v, e.c, e.r1, e.r2, e.d});
            check(s == e.s, "R10", {which, " seq"}, s, e.s);
        end else begin
            check(v == 1'b0, tag, {which, " bubble"}, v, 0);
        end
    endtask

    task automatic cmp_ret(input string which, input ref_t e, input logic v,
                           input logic [RW-1:0] d, input logic [SW-1:0] s);
        if (e.v) check(v && d == e.d && s == e.s, "R11", which, {v, d, s}, {e.v, e.d, e.s});
        else     check(v == 1'b0, "R11", {which, " idle"}, v, 0);
    endtask

    // inputs already driven at a negedge; runs one full clock
    task automatic cycle();
        ref_t na, nb;
        #1;
        exp_deq = ref_deq();
        check(deq_cnt == exp_deq[1:0], tag, "deq_cnt", deq_cnt, exp_deq);
        na = '0; nb = '0;
        if (exp_deq > 0) begin
            na = '{v: 1'b1, c: q0_cls, r1: q0_rs1, r2: q0_rs2, d: q0_rd, s: seq_ctr[SW-1:0]};
            if (exp_deq == 2)
                nb = '{v: 1'b1, c: q1_cls, r1: q1_rs1, r2: q1_rs2, d: q1_rd, s: SW'(seq_ctr + 1)};
        end
        @(posedge clk);
        wb_a = ex_a; wb_b = ex_b;
        ex_a = iss_a; ex_b = iss_b;
        iss_a = na; iss_b = nb;
        seq_ctr = (seq_ctr + exp_deq) % (1 << SW);
        @(negedge clk);
        cmp_issue("pipe A", iss_a, pa_valid, pa_cls, pa_rs1, pa_rs2, pa_rd, pa_seq);
        cmp_issue("pipe B", iss_b, pb_valid, pb_cls, pb_rs1, pb_rs2, pb_rd, pb_seq);
        cmp_ret("retire A", wb_a, rt_a_valid, rt_a_rd, rt_a_seq);
        cmp_ret("retire B", wb_b, rt_b_valid, rt_b_rd, rt_b_seq);
    endtask

    task automatic set0(input logic v, input logic [2:0] c, input logic [RW-1:0] r1,
                        input logic [RW-1:0] r2, input logic [RW-1:0] d);
        q0_valid = v; q0_cls = c; q0_rs1 = r1; q0_rs2 = r2; q0_rd = d;
    endtask

    task automatic set1(input logic v, input logic [2:0] c, input logic [RW-1:0] r1,
                        input logic [RW-1:0] r2, input logic [RW-1:0] d);
        q1_valid = v; q1_cls = c; q1_rs1 = r1; q1_rs2 = r2; q1_rd = d;
    endtask

    function automatic int rnd(input int m);
        lcg = lcg * 1103515245 + 12345;
        return ((lcg >>> 8) & 32'h7fff) % m;
    endfunction

    initial begin
        iss_a = '0; iss_b = '0; ex_a = '0; ex_b = '0; wb_a = '0; wb_b = '0;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!pa_valid && !pb_valid, "R1", "issue during reset", {pa_valid, pb_valid}, 0);
        check(!rt_a_valid && !rt_b_valid, "R1", "retire during reset", {rt_a_valid, rt_b_valid}, 0);
        rst_n = 1'b1;
        tag = "R1";
        set0(0, 0, 0, 0, 0); set1(0, 0, 0, 0, 0);
        cycle();
        // R1: first issue carries seq 0; single entry alone
        tag = "R1"; set0(1, 3'd0, 5'd1, 5'd2, 5'd3); cycle();
        // R2: empty and q1-only
        tag = "R2"; set0(0, 3'd0, 0, 0, 0); set1(1, 3'd0, 5'd4, 5'd5, 5'd6); cycle();
        // R3: only slot 0 valid
        tag = "R3"; set0(1, 3'd5, 5'd7, 5'd8, 5'd9); set1(0, 3'd0, 0, 0, 0); cycle();
        // R4: independent ALU pair
        tag = "R4"; set0(1, 3'd0, 5'd1, 5'd2, 5'd3); set1(1, 3'd1, 5'd4, 5'd5, 5'd6); cycle();
        // R5: restricted classes refused, allowed ones accepted
        tag = "R5"; set1(1, 3'd3, 5'd4, 5'd5, 5'd6); cycle();
        set1(1, 3'd5, 5'd4, 5'd5, 5'd6); cycle();
        set1(1, 3'd6, 5'd4, 5'd5, 5'd6); cycle();
        set1(1, 3'd2, 5'd4, 5'd5, 5'd6); cycle();
        set1(1, 3'd7, 5'd4, 5'd5, 5'd6); cycle();
        // R6: branch older refused, branch younger paired
        tag = "R6"; set0(1, 3'd4, 5'd1, 5'd2, 5'd0); set1(1, 3'd0, 5'd4, 5'd5, 5'd6); cycle();
        set0(1, 3'd0, 5'd1, 5'd2, 5'd3); set1(1, 3'd4, 5'd4, 5'd5, 5'd0); cycle();
        // R7: RAW via rs1, via rs2, and register 0 not a hazard
        tag = "R7"; set1(1, 3'd0, 5'd3, 5'd5, 5'd6); cycle();
        set1(1, 3'd0, 5'd4, 5'd3, 5'd6); cycle();
        set0(1, 3'd0, 5'd1, 5'd2, 5'd0); set1(1, 3'd0, 5'd0, 5'd0, 5'd0); cycle();
        // R8: WAW
        tag = "R8"; set0(1, 3'd2, 5'd1, 5'd2, 5'd9); set1(1, 3'd0, 5'd4, 5'd5, 5'd9); cycle();
        // R9: stall with a legal pair, then release
        tag = "R9"; set0(1, 3'd0, 5'd1, 5'd2, 5'd3); set1(1, 3'd0, 5'd4, 5'd5, 5'd6);
        stall = 1'b1; cycle(); cycle();
        stall = 1'b0; cycle();
        // R10 wrap and R11 drain via long random traffic
        tag = "R4";
        for (int i = 0; i < 3000; i++) begin
            stall = (rnd(8) == 0);
            set0(rnd(10) < 8, 3'(rnd(8)), 5'(rnd(8)), 5'(rnd(8)), 5'(rnd(8)));
            set1(rnd(10) < 7, 3'(rnd(8)), 5'(rnd(8)), 5'(rnd(8)), 5'(rnd(8)));
            cycle();
        end
        stall = 1'b0; set0(0, 0, 0, 0, 0); set1(0, 0, 0, 0, 0);
        tag = "R2";
        repeat (4) cycle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule